// File: doc/BRIEF.md
# Segmented RAM Write-Protection Checker

This block screens every RAM write against a small set of programmable address segments. Each segment has a start word address and an end word address. It also has two enables: one lets the segment apply to user-data writes, the other to supervisor-data writes. A mode input selects how a segment match is read:

- **Deny-list mode:** a matching segment is forbidden.
- **Allow-list mode:** only writes that match some segment may proceed.

A write that is refused has its memory write strobe removed in the same cycle. It also raises a fault strobe with a fault-type code, and one clock later it is reported to the fault-status logic with its address.

Software programs the segments through a simple register port. Reads are combinational. A register write that sets bits outside the defined fields is accepted, and it pulses a register-parity-error flag one cycle later. After reset every register is zero, so no segment is enabled and every write passes.

Top module: `wprot_checker`

## Requirements
- R1: After reset all segment registers read as zero, `reg_perr` and `rpt_valid` are low, and every write is allowed.
- R2: `reg_sel` bit 0 chooses the end register (1) or the start register (0); the upper bits index the segment. A start register reads back as its 23-bit word address in bits 22:0, ORed with its 2-bit enable field in bits 24:23. An end register reads back as its 23-bit word address.
- R3: The word address that is compared is byte-address bits 22:2, zero-extended. Address bits 31:23 and 1:0 have no effect on the decision.
- R4: A segment is considered for user-data writes (space code 0xA) only when enable bit 0 is set. It is considered for supervisor-data writes (space code 0xB) only when enable bit 1 is set. No other space code ever matches a segment.
- R5: A segment hits when the word address is at or above its start and below its end. For a double-word access (`acc_size` = 3) the word address has bit 0 forced to 1 before the end comparison.
- R6: With `blk_mode` = 1, a write that hits any segment is refused with fault type 1. Any other write is allowed.
- R7: With `blk_mode` = 0, a write that hits no segment is refused with fault type 2. Fault type 0 means no fault.
- R8: Checking is active only while at least one segment has a nonzero enable field. Otherwise every write is allowed in both modes.
- R9: `mem_we` equals `acc_valid` AND `acc_allow`, and `flt_strobe` equals `acc_valid` AND NOT `acc_allow`, both in the same cycle. With `acc_valid` low, neither is raised.
- R10: One cycle after a fault strobe, `rpt_valid` and `rpt_write` are high, and `rpt_addr`/`rpt_type` hold the faulting byte address and fault type. After an allowed write, `rpt_valid` is low.
- R11: Writing a start register with any of bits 31:25 set, or an end register with any of bits 31:23 set, pulses `reg_perr` in the following cycle. The defined fields are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write enable |
| reg_sel | input | SEL_W | Register select: bit 0 end/start, upper bits segment index |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| reg_perr | output | 1 | Register-parity-error pulse |
| blk_mode | input | 1 | 1 = segments forbidden, 0 = only segments allowed |
| acc_valid | input | 1 | Write request present |
| acc_addr | input | ADDR_W | Byte address of the write |
| acc_space | input | SPACE_W | Access-space code |
| acc_size | input | 2 | 0 byte, 1 half, 2 word, 3 double |
| acc_allow | output | 1 | Write permitted |
| mem_we | output | 1 | Write strobe to memory |
| flt_strobe | output | 1 | Protection fault this cycle |
| flt_type | output | 2 | Fault type of the current write |
| rpt_valid | output | 1 | Registered fault report valid |
| rpt_addr | output | ADDR_W | Reported faulting address |
| rpt_type | output | 2 | Reported fault type |
| rpt_write | output | 1 | Reported fault was a write |

## Verification
The bench builds the block with its default parameters: two segments, a 23-bit word address and a 32-bit register word. Two segments are enough to place one user-only range and one supervisor-only range side by side. With a segment end set to an odd word address, the double-word rounding is visible at the last word of the segment. The 32-bit data word leaves reserved bits above both field layouts, so out-of-field writes can be driven on start and end registers alike.

// File: rtl/wprot_pkg.sv
package wprot_pkg;

    typedef enum logic [1:0] {
        FT_NONE    = 2'd0,
        FT_SEG_HIT = 2'd1,
        FT_NO_SEG  = 2'd2
    } flt_type_e;

    localparam int EN_W         = 2;
    localparam int SPACE_USER_D = 'hA;
    localparam int SPACE_SUPV_D = 'hB;
    localparam logic [1:0] SZ_DOUBLE = 2'd3;

endpackage

// File: rtl/wprot_regs.sv
module wprot_regs
    import wprot_pkg::*;
#(
    parameter int NSEG    = 2,
    parameter int WADDR_W = 23,
    parameter int DATA_W  = 32,
    parameter int SEL_W   = 2
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               reg_we,
    input  logic [SEL_W-1:0]                   reg_sel,
    input  logic [DATA_W-1:0]                  reg_wdata,
    output logic [DATA_W-1:0]                  reg_rdata,
    output logic                               reg_perr,
    output logic [NSEG-1:0][WADDR_W-1:0]       seg_start,
    output logic [NSEG-1:0][WADDR_W-1:0]       seg_end,
    output logic [NSEG-1:0][EN_W-1:0]          seg_en,
    output logic                               any_en
);

    localparam int IDX_W    = SEL_W - 1;
    localparam int START_HI = WADDR_W + EN_W;

    typedef struct packed {
        logic [NSEG-1:0][WADDR_W-1:0] start;
        logic [NSEG-1:0][WADDR_W-1:0] stop;
        logic [NSEG-1:0][EN_W-1:0]    en;
        logic                         perr;
    } regs_t;

    regs_t st_d, st_q;
    logic [IDX_W-1:0] idx;

    assign idx = reg_sel[SEL_W-1:1];

    always_comb begin
        st_d      = st_q;
        st_d.perr = 1'b0;
        if (reg_we && (int'(idx) < NSEG)) begin
            if (!reg_sel[0]) begin
                st_d.start[idx] = reg_wdata[WADDR_W-1:0];
                st_d.en[idx]    = reg_wdata[WADDR_W +: EN_W];
                st_d.perr       = |reg_wdata[DATA_W-1:START_HI];
            end else begin
                st_d.stop[idx]  = reg_wdata[WADDR_W-1:0];
                st_d.perr       = |reg_wdata[DATA_W-1:WADDR_W];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        reg_rdata = '0;
        if (int'(idx) < NSEG) begin
            if (!reg_sel[0]) begin
                reg_rdata[WADDR_W-1:0]     = st_q.start[idx];
                reg_rdata[WADDR_W +: EN_W] = st_q.en[idx];
            end else begin
                reg_rdata[WADDR_W-1:0]     = st_q.stop[idx];
            end
        end
    end

    assign seg_start = st_q.start;
    assign seg_end   = st_q.stop;
    assign seg_en    = st_q.en;
    assign any_en    = |st_q.en;
    assign reg_perr  = st_q.perr;

    // R11: the error pulse only ever follows a register write
    p_perr_after_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_perr |-> $past(reg_we));

endmodule

// File: rtl/wprot_seg_match.sv
module wprot_seg_match
    import wprot_pkg::*;
#(
    parameter int WADDR_W = 23
) (
    input  logic [WADDR_W-1:0] waddr,
    input  logic               is_dbl,
    input  logic               sp_user,
    input  logic               sp_supv,
    input  logic [WADDR_W-1:0] lo,
    input  logic [WADDR_W-1:0] hi,
    input  logic [EN_W-1:0]    en,
    output logic               hit
);

    logic [WADDR_W-1:0] top_word;
    logic               space_ok;

    always_comb begin
        top_word    = waddr;
        top_word[0] = waddr[0] | is_dbl;
        space_ok    = (en[0] & sp_user) | (en[1] & sp_supv);
        hit         = space_ok && (waddr >= lo) && (top_word < hi);
    end

endmodule

// File: rtl/wprot_fault_report.sv
module wprot_fault_report
    import wprot_pkg::*;
#(
    parameter int ADDR_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flt_strobe,
    input  logic [ADDR_W-1:0] flt_addr,
    input  flt_type_e         flt_type,
    output logic              rpt_valid,
    output logic [ADDR_W-1:0] rpt_addr,
    output logic [1:0]        rpt_type,
    output logic              rpt_write
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        flt_type_e         ftype;
    } rpt_t;

    rpt_t rp_d, rp_q;

    always_comb begin
        rp_d       = rp_q;
        rp_d.valid = flt_strobe;
        if (flt_strobe) begin
            rp_d.addr  = flt_addr;
            rp_d.ftype = flt_type;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rp_q <= '0;
        else        rp_q <= rp_d;
    end

    assign rpt_valid = rp_q.valid;
    assign rpt_addr  = rp_q.addr;
    assign rpt_type  = rp_q.ftype;
    assign rpt_write = rp_q.valid;

    // R10: a fault is reported on the next cycle with its address
    p_report_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flt_strobe |=> (rpt_valid && rpt_addr == $past(flt_addr)));

endmodule

// File: rtl/wprot_checker.sv
module wprot_checker
    import wprot_pkg::*;
#(
    parameter int NSEG      = 2,
    parameter int WADDR_W   = 23,
    parameter int MASK_BITS = 23,
    parameter int ADDR_W    = 32,
    parameter int DATA_W    = 32,
    parameter int SPACE_W   = 8,
    localparam int IDX_W    = (NSEG > 1) ? $clog2(NSEG) : 1,
    localparam int SEL_W    = IDX_W + 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                reg_we,
    input  logic [SEL_W-1:0]    reg_sel,
    input  logic [DATA_W-1:0]   reg_wdata,
    output logic [DATA_W-1:0]   reg_rdata,
    output logic                reg_perr,
    input  logic                blk_mode,
    input  logic                acc_valid,
    input  logic [ADDR_W-1:0]   acc_addr,
    input  logic [SPACE_W-1:0]  acc_space,
    input  logic [1:0]          acc_size,
    output logic                acc_allow,
    output logic                mem_we,
    output logic                flt_strobe,
    output logic [1:0]          flt_type,
    output logic                rpt_valid,
    output logic [ADDR_W-1:0]   rpt_addr,
    output logic [1:0]          rpt_type,
    output logic                rpt_write
);

    localparam int WBITS = MASK_BITS - 2;

    logic [NSEG-1:0][WADDR_W-1:0] seg_start, seg_end;
    logic [NSEG-1:0][EN_W-1:0]    seg_en;
    logic                         any_en;
    logic [NSEG-1:0]              seg_hit;
    logic [WADDR_W-1:0]           waddr;
    logic                         sp_user, sp_supv, is_dbl;
    logic                         fault;
    flt_type_e                    ftype;

    wprot_regs #(
        .NSEG(NSEG), .WADDR_W(WADDR_W), .DATA_W(DATA_W), .SEL_W(SEL_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_perr(reg_perr),
        .seg_start(seg_start), .seg_end(seg_end), .seg_en(seg_en),
        .any_en(any_en)
    );

    always_comb begin
        waddr   = '0;
        waddr[WBITS-1:0] = acc_addr[MASK_BITS-1:2];
        sp_user = (acc_space == SPACE_W'(SPACE_USER_D));
        sp_supv = (acc_space == SPACE_W'(SPACE_SUPV_D));
        is_dbl  = (acc_size == SZ_DOUBLE);
    end

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        wprot_seg_match #(.WADDR_W(WADDR_W)) u_match (
            .waddr(waddr), .is_dbl(is_dbl), .sp_user(sp_user),
            .sp_supv(sp_supv), .lo(seg_start[g]), .hi(seg_end[g]),
            .en(seg_en[g]), .hit(seg_hit[g])
        );
    end

    always_comb begin
        if (!any_en)       fault = 1'b0;
        else if (blk_mode) fault = |seg_hit;
        else               fault = ~|seg_hit;
        if (!fault)        ftype = FT_NONE;
        else if (blk_mode) ftype = FT_SEG_HIT;
        else               ftype = FT_NO_SEG;
    end

    assign acc_allow  = ~fault;
    assign mem_we     = acc_valid & ~fault;
    assign flt_strobe = acc_valid & fault;
    assign flt_type   = acc_valid ? ftype : FT_NONE;

    wprot_fault_report #(.ADDR_W(ADDR_W)) u_report (
        .clk(clk), .rst_n(rst_n), .flt_strobe(flt_strobe),
        .flt_addr(acc_addr), .flt_type(ftype), .rpt_valid(rpt_valid),
        .rpt_addr(rpt_addr), .rpt_type(rpt_type), .rpt_write(rpt_write)
    );

    // R8: with no segment enabled every write passes
    p_off_allows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !any_en |-> acc_allow);

    // R9: a valid write either reaches memory or faults, never both
    p_we_or_fault_r9: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid |-> (mem_we != flt_strobe));

    // R6: a fault always carries a nonzero type code
    p_fault_typed_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flt_strobe |-> (flt_type != 2'd0));

    // R10: the registered report copies the type of the previous fault
    p_report_type_r10: assert property (@(posedge clk) disable iff (!rst_n)
        flt_strobe |=> (rpt_type == $past(flt_type)));

endmodule

// File: tb/wprot_checker_bench.sv
module wprot_checker_bench;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        reg_perr;
    logic        blk_mode = 1'b1;
    logic        acc_valid = 1'b0;
    logic [31:0] acc_addr = '0;
    logic [7:0]  acc_space = '0;
    logic [1:0]  acc_size = '0;
    logic        acc_allow, mem_we, flt_strobe;
    logic [1:0]  flt_type;
    logic        rpt_valid;
    logic [31:0] rpt_addr;
    logic [1:0]  rpt_type;
    logic        rpt_write;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wprot_checker u_wprot_checker (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_perr(reg_perr),
        .blk_mode(blk_mode), .acc_valid(acc_valid), .acc_addr(acc_addr),
        .acc_space(acc_space), .acc_size(acc_size), .acc_allow(acc_allow),
        .mem_we(mem_we), .flt_strobe(flt_strobe), .flt_type(flt_type),
        .rpt_valid(rpt_valid), .rpt_addr(rpt_addr), .rpt_type(rpt_type),
        .rpt_write(rpt_write)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // register write; perr is checked one cycle later
    task automatic wr_reg(logic [1:0] sel, logic [31:0] data, bit exp_perr, string req);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = sel; reg_wdata = data;
        @(negedge clk);
        reg_we = 1'b0;
        #1 chk(req, {31'd0, reg_perr}, {31'd0, exp_perr});
    endtask

    task automatic rd_reg(logic [1:0] sel, logic [31:0] exp, string req);
        @(negedge clk);
        reg_sel = sel;
        #1 chk(req, reg_rdata, exp);
    endtask

    // one write access; exp_type 0 means allowed
    task automatic access(logic [31:0] a, logic [7:0] sp, logic [1:0] sz,
                          logic [1:0] exp_type, string req);
        @(negedge clk);
        acc_valid = 1'b1; acc_addr = a; acc_space = sp; acc_size = sz;
        #1;
        chk(req, {30'd0, acc_allow, mem_we}, {30'd0, exp_type == 0, exp_type == 0});
        chk(req, {29'd0, flt_strobe, flt_type}, {29'd0, exp_type != 0, exp_type});
        @(negedge clk);
        chk(req, {29'd0, rpt_valid, rpt_write, 1'b0}, {29'd0, exp_type != 0, exp_type != 0, 1'b0});
        if (exp_type != 0) begin
            chk(req, rpt_addr, a);
            chk(req, {30'd0, rpt_type}, {30'd0, exp_type});
        end
        acc_valid = 1'b0;
    endtask

    task automatic t_reset;
        for (int i = 0; i < 4; i++) rd_reg(2'(i), 32'd0, "R1 reg zero");
        chk("R1 perr", {31'd0, reg_perr}, 32'd0);
        chk("R1 rpt", {31'd0, rpt_valid}, 32'd0);
        access(32'h0000_0400, 8'hA, 2'd2, 2'd0, "R1 allow after reset");
    endtask

    task automatic t_program;
        wr_reg(2'b00, 32'h0080_0100, 1'b0, "R11 clean start");
        wr_reg(2'b01, 32'h0000_0200, 1'b0, "R11 clean end");
        wr_reg(2'b10, 32'h0100_0400, 1'b0, "R11 clean start1");
        wr_reg(2'b11, 32'h0000_0403, 1'b0, "R11 clean end1");
        rd_reg(2'b00, 32'h0080_0100, "R2 start0 readback");
        rd_reg(2'b01, 32'h0000_0200, "R2 end0 readback");
        rd_reg(2'b10, 32'h0100_0400, "R2 start1 readback");
        rd_reg(2'b11, 32'h0000_0403, "R2 end1 readback");
    endtask

    task automatic t_block;
        blk_mode = 1'b1;
        access(32'h0000_0400, 8'hA, 2'd2, 2'd1, "R6 user hit seg0");
        access(32'h0000_03FC, 8'hA, 2'd2, 2'd0, "R5 below start");
        access(32'h0000_07FC, 8'hA, 2'd2, 2'd1, "R5 last word");
        access(32'h0000_0800, 8'hA, 2'd2, 2'd0, "R5 at end");
        access(32'hFF80_0403, 8'hA, 2'd0, 2'd1, "R3 high bits ignored");
        access(32'h0000_0400, 8'hB, 2'd2, 2'd0, "R4 supv vs user-only seg");
        access(32'h0000_1000, 8'hB, 2'd2, 2'd1, "R4 supv hit seg1");
        access(32'h0000_1000, 8'hA, 2'd2, 2'd0, "R4 user vs supv-only seg");
        access(32'h0000_1008, 8'hB, 2'd2, 2'd1, "R5 word at last");
        access(32'h0000_1008, 8'hB, 2'd3, 2'd0, "R5 double rounds up");
        access(32'h0000_0400, 8'h9, 2'd2, 2'd0, "R4 other space no hit");
    endtask

    task automatic t_allow;
        blk_mode = 1'b0;
        access(32'h0000_0400, 8'hA, 2'd2, 2'd0, "R7 inside allowed");
        access(32'h0000_03FC, 8'hA, 2'd2, 2'd2, "R7 outside refused");
        access(32'h0000_0400, 8'h9, 2'd2, 2'd2, "R7 other space refused");
        access(32'h0000_1008, 8'hB, 2'd3, 2'd2, "R7 double beyond end");
    endtask

    task automatic t_idle;
        blk_mode = 1'b1;
        @(negedge clk);
        acc_valid = 1'b0; acc_addr = 32'h0000_0400; acc_space = 8'hA; acc_size = 2'd2;
        #1 chk("R9 idle no strobes", {30'd0, mem_we, flt_strobe}, 32'd0);
        @(negedge clk);
        chk("R10 idle no report", {31'd0, rpt_valid}, 32'd0);
    endtask

    task automatic t_parity;
        wr_reg(2'b00, 32'h0200_0100, 1'b1, "R11 start bit25");
        rd_reg(2'b00, 32'h0000_0100, "R11 start stored");
        wr_reg(2'b01, 32'h0080_0200, 1'b1, "R11 end bit23");
        rd_reg(2'b01, 32'h0000_0200, "R11 end stored");
    endtask

    task automatic t_disabled;
        wr_reg(2'b10, 32'h0000_0400, 1'b0, "R8 clear en1");
        blk_mode = 1'b0;
        access(32'h0000_0000, 8'hA, 2'd2, 2'd0, "R8 off allow-list");
        blk_mode = 1'b1;
        access(32'h0000_0400, 8'hA, 2'd2, 2'd0, "R8 off deny-list");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_program();
        t_block();
        t_allow();
        t_idle();
        t_parity();
        t_disabled();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_fail++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule